// File: doc/BRIEF.md
# I2C Register Target

This block is an I2C target that gives an external bus controller byte-wide access to a bank of up to 256 registers. It does not hold the registers itself. It drives a one-cycle write strobe with an address and data, and it presents a read address on which the register file returns data combinationally. SCL and SDA are resynchronised and glitch-filtered against the fast system clock. START, repeated START and STOP are decoded from the filtered lines.

A transaction begins with an address byte. Its upper six bits are fixed at 010110, the next bit comes from a strap input, and the last bit selects read (1) or write (0). In a write, the first byte after the address loads an internal sub-address pointer. Every later byte is stored at the pointer, and the pointer then steps. A read streams bytes starting at the pointer, which is 00h after reset. The pointer steps after every byte sent, so reads and writes share one running position. SDA is open-drain: the block only pulls the line low or releases it.

Top module: `i2c_reg_target`

## Requirements
- R1: The block acknowledges (pulls SDA low during the ninth clock) an address byte exactly when bits 7..1 equal {010110, strap}. This gives 0x58/0x59 for strap 0 and 0x5A/0x5B for strap 1. Any other address is left unacknowledged and causes no register write.
- R2: While the enable input is low, SDA is released, no byte is acknowledged and no write strobe is issued.
- R3: In a write, the byte after the address loads the pointer. Each following byte is acknowledged and produces a single-cycle write strobe at the pointer, after which the pointer is one higher.
- R4: A write that carries only the sub-address and then STOP sets the pointer without writing any register.
- R5: After reset the pointer is 00h, so a read with no prior write starts at register 00h.
- R6: A read sends register data MSB first. The pointer advances after every transmitted byte, and a controller ACK is followed by the byte at the advanced pointer.
- R7: After a controller NACK the block releases SDA and does not drive it again, nor move the pointer, until the next START.
- R8: STOP ends any transaction, releases SDA and returns the block to waiting for START. Reset leaves SDA released.
- R9: A repeated START returns the block to address reception and keeps the pointer value.
- R10: The pointer wraps from FFh to 00h on both writes and reads.
- R11: The block asserts its SDA pull only while SCL is low, at least one system clock after SCL falls. This meets 400 kbit/s timing.
- R12: SCL or SDA pulses shorter than three system clocks, after the two-stage synchroniser, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Interface enable |
| addr_lsb_i | input | 1 | Strap for bit 0 of the 7-bit target address |
| scl_i | input | 1 | Sensed SCL line |
| sda_i | input | 1 | Sensed SDA line |
| sda_pull_o | output | 1 | 1 pulls SDA low, 0 releases it |
| reg_we_o | output | 1 | Single-cycle register write strobe |
| reg_waddr_o | output | ADDR_W | Register write address |
| reg_wdata_o | output | 8 | Register write data |
| reg_raddr_o | output | ADDR_W | Read address (current pointer) |
| reg_rdata_i | input | 8 | Register data at reg_raddr_o |

## Verification
The hardest states to reach from the pins are the ones that follow a controller NACK. In those states the controller keeps toggling SCL, and the target must keep silent while its pointer stays frozen. The bench reaches them by refusing a read byte and then clocking two more full bytes with SDA released. It watches the pull output across every cycle of those bytes. Pointer wrap is reached with a burst write that starts at sub-address FEh. Filter rejection is reached by injecting two-cycle SCL pulses inside the low phase of each data bit and confirming the stored byte is unchanged.

// File: rtl/i2c_tgt_pkg.sv
`timescale 1ns/1ps
package i2c_tgt_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 4;
  localparam logic [5:0] TGT_ADDR_HI = 6'b010110;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK_DRV,
    ST_TX,
    ST_ACK_CHK,
    ST_WAIT
  } tgt_state_e;

  typedef enum logic [1:0] {
    PH_ADDR,
    PH_SUB,
    PH_DATA
  } byte_phase_e;
endpackage

// File: rtl/i2c_line_filter.sv
`timescale 1ns/1ps
module i2c_line_filter #(
  parameter int SYNC_LEN = 2,
  parameter int FILT_LEN = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic line_o
);
  logic [SYNC_LEN-1:0] sync_q;
  logic [FILT_LEN-1:0] hist_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      hist_q <= '1;
      line_o <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_LEN-2:0], line_i};
      hist_q <= {hist_q[FILT_LEN-2:0], sync_q[SYNC_LEN-1]};
      // output moves only when the whole window agrees
      if (&hist_q)       line_o <= 1'b1;
      else if (~|hist_q) line_o <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_bus_events.sv
`timescale 1ns/1ps
module i2c_bus_events (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/i2c_byte_engine.sv
`timescale 1ns/1ps
module i2c_byte_engine
  import i2c_tgt_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              addr_lsb_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              sda_i,
  output logic              sda_pull_o,
  output logic              we_o,
  output logic [ADDR_W-1:0] waddr_o,
  output logic [BYTE_W-1:0] wdata_o,
  output logic [ADDR_W-1:0] ptr_o,
  input  logic [BYTE_W-1:0] rdata_i
);
  localparam logic [CNT_W-1:0] BIT_FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(BYTE_W - 1);

  tgt_state_e          state_q;
  byte_phase_e         phase_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [BYTE_W-1:0]   rx_q;
  logic [BYTE_W-1:0]   tx_q;
  logic [ADDR_W-1:0]   ptr_q;
  logic                rd_q;
  logic                acked_q;
  logic                addr_hit;

  assign addr_hit = (rx_q[BYTE_W-1:1] == {TGT_ADDR_HI, addr_lsb_i});
  assign ptr_o    = ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      phase_q    <= PH_ADDR;
      cnt_q      <= '0;
      rx_q       <= '0;
      tx_q       <= '0;
      ptr_q      <= '0;
      rd_q       <= 1'b0;
      acked_q    <= 1'b0;
      sda_pull_o <= 1'b0;
      we_o       <= 1'b0;
      waddr_o    <= '0;
      wdata_o    <= '0;
    end else begin
      we_o <= 1'b0;
      if (!en_i || stop_i) begin
        state_q    <= ST_IDLE;
        sda_pull_o <= 1'b0;
      end else if (start_i) begin
        state_q    <= ST_RX;
        phase_q    <= PH_ADDR;
        cnt_q      <= '0;
        sda_pull_o <= 1'b0;
      end else begin
        unique case (state_q)
          ST_RX: begin
            if (scl_rise_i && cnt_q != BIT_FULL) begin
              rx_q  <= {rx_q[BYTE_W-2:0], sda_i};
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall_i && cnt_q == BIT_FULL) begin
              cnt_q <= '0;
              unique case (phase_q)
                PH_ADDR: begin
                  if (addr_hit) begin
                    rd_q       <= rx_q[0];
                    sda_pull_o <= 1'b1;
                    state_q    <= ST_ACK_DRV;
                  end else begin
                    state_q <= ST_WAIT;
                  end
                end
                PH_SUB: begin
                  ptr_q      <= rx_q[ADDR_W-1:0];
                  sda_pull_o <= 1'b1;
                  state_q    <= ST_ACK_DRV;
                end
                default: begin
                  we_o       <= 1'b1;
                  waddr_o    <= ptr_q;
                  wdata_o    <= rx_q;
                  ptr_q      <= ptr_q + 1'b1;
                  sda_pull_o <= 1'b1;
                  state_q    <= ST_ACK_DRV;
                end
              endcase
            end
          end
          ST_ACK_DRV: begin
            if (scl_fall_i) begin
              cnt_q <= '0;
              if (phase_q == PH_ADDR && rd_q) begin
                phase_q    <= PH_DATA;
                tx_q       <= rdata_i;
                sda_pull_o <= ~rdata_i[BYTE_W-1];
                state_q    <= ST_TX;
              end else begin
                phase_q    <= (phase_q == PH_ADDR) ? PH_SUB : PH_DATA;
                sda_pull_o <= 1'b0;
                state_q    <= ST_RX;
              end
            end
          end
          ST_TX: begin
            if (scl_fall_i) begin
              if (cnt_q == BIT_LAST) begin
                sda_pull_o <= 1'b0;
                ptr_q      <= ptr_q + 1'b1;
                state_q    <= ST_ACK_CHK;
              end else begin
                tx_q       <= {tx_q[BYTE_W-2:0], 1'b0};
                sda_pull_o <= ~tx_q[BYTE_W-2];
                cnt_q      <= cnt_q + 1'b1;
              end
            end
          end
          ST_ACK_CHK: begin
            if (scl_rise_i) acked_q <= ~sda_i;
            if (scl_fall_i) begin
              cnt_q <= '0;
              if (acked_q) begin
                tx_q       <= rdata_i;
                sda_pull_o <= ~rdata_i[BYTE_W-1];
                state_q    <= ST_TX;
              end else begin
                state_q <= ST_WAIT;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_reg_target.sv
`timescale 1ns/1ps
module i2c_reg_target
  import i2c_tgt_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int SYNC_LEN = 2,
  parameter int FILT_LEN = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              addr_lsb_i,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_pull_o,
  output logic              reg_we_o,
  output logic [ADDR_W-1:0] reg_waddr_o,
  output logic [BYTE_W-1:0] reg_wdata_o,
  output logic [ADDR_W-1:0] reg_raddr_o,
  input  logic [BYTE_W-1:0] reg_rdata_i
);
  localparam int N_LINES = 2;

  logic [N_LINES-1:0] line_raw;
  logic [N_LINES-1:0] line_filt;
  logic scl_filt, sda_filt;
  logic scl_rise, scl_fall, start_det, stop_det;

  assign line_raw = {scl_i, sda_i};

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    i2c_line_filter #(
      .SYNC_LEN(SYNC_LEN),
      .FILT_LEN(FILT_LEN)
    ) u_filt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .line_i(line_raw[g]),
      .line_o(line_filt[g])
    );
  end

  assign scl_filt = line_filt[1];
  assign sda_filt = line_filt[0];

  i2c_bus_events u_events (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_i     (scl_filt),
    .sda_i     (sda_filt),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (start_det),
    .stop_o    (stop_det)
  );

  i2c_byte_engine #(
    .ADDR_W(ADDR_W)
  ) u_engine (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .addr_lsb_i(addr_lsb_i),
    .scl_rise_i(scl_rise),
    .scl_fall_i(scl_fall),
    .start_i   (start_det),
    .stop_i    (stop_det),
    .sda_i     (sda_filt),
    .sda_pull_o(sda_pull_o),
    .we_o      (reg_we_o),
    .waddr_o   (reg_waddr_o),
    .wdata_o   (reg_wdata_o),
    .ptr_o     (reg_raddr_o),
    .rdata_i   (reg_rdata_i)
  );
endmodule

// File: rtl/i2c_reg_target_chk.sv
`timescale 1ns/1ps
module i2c_reg_target_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic              scl_f,
  input logic              start_p,
  input logic              stop_p,
  input logic              sda_pull_o,
  input logic              reg_we_o,
  input logic [ADDR_W-1:0] reg_waddr_o,
  input logic [ADDR_W-1:0] reg_raddr_o
);
  p_release_when_off_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !sda_pull_o);

  p_we_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> !reg_we_o);

  p_ptr_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> (reg_raddr_o == reg_waddr_o + 1'b1));

  p_stop_release_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_p |=> !sda_pull_o);

  p_start_release_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_p |=> !sda_pull_o);

  p_pull_scl_low_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_pull_o) |-> !scl_f);

  p_we_scl_low_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> !scl_f);
endmodule

bind i2c_reg_target i2c_reg_target_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (en_i),
  .scl_f      (scl_filt),
  .start_p    (start_det),
  .stop_p     (stop_det),
  .sda_pull_o (sda_pull_o),
  .reg_we_o   (reg_we_o),
  .reg_waddr_o(reg_waddr_o),
  .reg_raddr_o(reg_raddr_o)
);

// File: tb/sim_i2c_reg_target.sv
`timescale 1ns/1ps
module sim_i2c_reg_target;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b1;
  logic lsb = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic pull, we;
  logic [7:0] waddr, wdata, raddr, rdata;
  logic sda_line;
  logic [7:0] regs [256];
  int n_chk = 0, n_err = 0, wr_count = 0, pull_cycles = 0, oe_viol = 0;
  logic pull_q = 1'b0;
  bit done = 0;

  always #5 clk = ~clk;

  assign sda_line = m_sda & ~pull;
  assign rdata = regs[raddr];

  i2c_reg_target u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .addr_lsb_i(lsb),
    .scl_i(m_scl), .sda_i(sda_line), .sda_pull_o(pull),
    .reg_we_o(we), .reg_waddr_o(waddr), .reg_wdata_o(wdata),
    .reg_raddr_o(raddr), .reg_rdata_i(rdata)
  );

  function automatic logic [7:0] init_val(int i);
    return 8'(i * 7 + 8'h3C);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) regs[i] <= init_val(i);
    end else if (we) begin
      regs[waddr] <= wdata;
    end
  end

  always @(posedge clk) begin
    if (rst_n && we) wr_count++;
    if (rst_n && pull) pull_cycles++;
    if (rst_n && (pull !== pull_q) && m_scl) oe_viol++;
    pull_q <= pull;
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_start();
    if (!m_scl) begin
      cyc(Q); m_sda = 1'b1; cyc(Q); m_scl = 1'b1; cyc(2*Q);
    end
    m_sda = 1'b0; cyc(2*Q); m_scl = 1'b0;
  endtask

  task automatic bus_stop();
    cyc(Q); m_sda = 1'b0; cyc(Q); m_scl = 1'b1; cyc(2*Q); m_sda = 1'b1; cyc(2*Q);
  endtask

  task automatic put_byte(input logic [7:0] b, input bit glitch, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      cyc(Q); m_sda = b[i];
      if (glitch) begin
        cyc(1); m_scl = 1'b1; cyc(2); m_scl = 1'b0; cyc(Q-3);
      end else begin
        cyc(Q);
      end
      m_scl = 1'b1; cyc(2*Q); m_scl = 1'b0;
    end
    cyc(Q); m_sda = 1'b1; cyc(Q); m_scl = 1'b1; cyc(Q);
    ack = !sda_line;
    cyc(Q); m_scl = 1'b0;
  endtask

  task automatic get_byte(input bit ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      cyc(Q); m_sda = 1'b1; cyc(Q); m_scl = 1'b1; cyc(Q);
      b[i] = sda_line;
      cyc(Q); m_scl = 1'b0;
    end
    cyc(Q); m_sda = !ack; cyc(Q); m_scl = 1'b1; cyc(2*Q); m_scl = 1'b0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  initial begin
    bit ack;
    logic [7:0] b;
    int w0, p0;
    cyc(3); rst_n = 1'b1; cyc(4);
    check(pull == 1'b0, "R8 reset releases SDA", pull, 0);
    check(we == 1'b0, "R3 no strobe after reset", we, 0);
    check(raddr == 8'h00, "R5 pointer after reset", raddr, 0);

    // R5/R6: fresh read starts at 00h
    bus_start(); put_byte(8'h59, 0, ack);
    check(ack, "R1 read address 0x59 acked", ack, 1);
    get_byte(1, b); check(b == init_val(0), "R5 first byte from 00h", b, init_val(0));
    get_byte(0, b); check(b == init_val(1), "R6 next byte after ACK", b, init_val(1));
    bus_stop();
    check(raddr == 8'h02, "R6 pointer after two reads", raddr, 2);

    // R3: multi-byte write
    w0 = wr_count;
    bus_start(); put_byte(8'h58, 0, ack);
    check(ack, "R1 write address 0x58 acked", ack, 1);
    put_byte(8'h10, 0, ack); check(ack, "R3 sub-address acked", ack, 1);
    for (int k = 0; k < 3; k++) begin
      put_byte(8'(8'h11 * (k + 1)), 0, ack);
      check(ack, "R3 data byte acked", ack, 1);
    end
    bus_stop();
    check(wr_count - w0 == 3, "R3 write strobe count", wr_count - w0, 3);
    check(raddr == 8'h13, "R3 pointer after burst", raddr, 8'h13);

    // R4: sub-address only, then read back
    w0 = wr_count;
    bus_start(); put_byte(8'h58, 0, ack); put_byte(8'h10, 0, ack); bus_stop();
    check(raddr == 8'h10, "R4 pointer set by sub-address", raddr, 8'h10);
    check(wr_count == w0, "R4 no register write", wr_count - w0, 0);
    bus_start(); put_byte(8'h59, 0, ack);
    for (int k = 0; k < 3; k++) begin
      get_byte(k != 2, b);
      check(b == 8'(8'h11 * (k + 1)), "R6 burst read of written data", b, 8'(8'h11 * (k + 1)));
    end
    bus_stop();
    bus_start(); put_byte(8'h59, 0, ack); get_byte(0, b); bus_stop();
    check(b == init_val(8'h13), "R6 read continues at pointer", b, init_val(8'h13));

    // R10: wrap
    bus_start(); put_byte(8'h58, 0, ack); put_byte(8'hFE, 0, ack);
    put_byte(8'hAA, 0, ack); put_byte(8'hBB, 0, ack); put_byte(8'hCC, 0, ack); bus_stop();
    check(raddr == 8'h01, "R10 write pointer wraps", raddr, 1);
    check(regs[8'h00] == 8'hCC, "R10 byte written at 00h", regs[0], 8'hCC);
    bus_start(); put_byte(8'h58, 0, ack); put_byte(8'hFF, 0, ack); bus_stop();
    bus_start(); put_byte(8'h59, 0, ack);
    get_byte(1, b); check(b == 8'hBB, "R10 read at FFh", b, 8'hBB);
    get_byte(0, b); check(b == 8'hCC, "R10 read wraps to 00h", b, 8'hCC);
    bus_stop();

    // R9: repeated START keeps pointer
    bus_start(); put_byte(8'h58, 0, ack); put_byte(8'h40, 0, ack);
    bus_start(); put_byte(8'h59, 0, ack);
    check(ack, "R9 address after repeated START acked", ack, 1);
    get_byte(0, b); bus_stop();
    check(b == init_val(8'h40), "R9 read at kept pointer", b, init_val(8'h40));
    check(raddr == 8'h41, "R9 pointer after read", raddr, 8'h41);

    // R7: NACK then more clocks
    bus_start(); put_byte(8'h59, 0, ack); get_byte(0, b);
    check(b == init_val(8'h41), "R7 byte before NACK", b, init_val(8'h41));
    p0 = pull_cycles;
    get_byte(1, b); check(b == 8'hFF, "R7 line released after NACK", b, 8'hFF);
    get_byte(1, b);
    check(pull_cycles == p0, "R7 no drive after NACK", pull_cycles - p0, 0);
    check(raddr == 8'h42, "R7 pointer frozen after NACK", raddr, 8'h42);
    bus_stop();

    // R8: STOP right after address
    w0 = wr_count;
    bus_start(); put_byte(8'h58, 0, ack); bus_stop();
    check(pull == 1'b0, "R8 SDA released after STOP", pull, 0);
    check(raddr == 8'h42 && wr_count == w0, "R8 STOP leaves pointer", raddr, 8'h42);
    bus_start(); put_byte(8'h59, 0, ack); get_byte(0, b); bus_stop();
    check(b == init_val(8'h42), "R8 next transaction after STOP", b, init_val(8'h42));

    // R2: disabled
    en = 1'b0; w0 = wr_count; p0 = pull_cycles;
    bus_start(); put_byte(8'h58, 0, ack);
    check(!ack, "R2 no ACK while disabled", ack, 0);
    put_byte(8'h20, 0, ack); put_byte(8'h99, 0, ack); bus_stop();
    check(wr_count == w0 && pull_cycles == p0, "R2 no write or drive while disabled", wr_count - w0, 0);
    check(raddr == 8'h43, "R2 pointer untouched while disabled", raddr, 8'h43);
    en = 1'b1;

    // R12: glitches on SCL inside data bits
    w0 = wr_count;
    bus_start(); put_byte(8'h58, 1, ack); check(ack, "R12 glitched address acked", ack, 1);
    put_byte(8'h70, 1, ack); put_byte(8'h5A, 1, ack); bus_stop();
    check(wr_count - w0 == 1, "R12 one write despite glitches", wr_count - w0, 1);
    check(regs[8'h70] == 8'h5A, "R12 glitch-free data stored", regs[8'h70], 8'h5A);

    // R1: address sweep for both strap values
    for (int s = 0; s < 2; s++) begin
      lsb = s[0];
      for (int a = 0; a < 128; a++) begin
        bit exp_ack;
        exp_ack = (7'(a) == {6'b010110, s[0]});
        bus_start(); put_byte({7'(a), 1'b0}, 0, ack); bus_stop();
        check(ack == exp_ack, "R1 address match sweep", {a, ack}, {a, exp_ack});
      end
    end
    lsb = 1'b1;
    bus_start(); put_byte(8'h5B, 0, ack); get_byte(0, b); bus_stop();
    check(ack, "R1 read address 0x5B acked", ack, 1);

    check(oe_viol == 0, "R11 SDA pull changes only with SCL low", oe_viol, 0);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual=%0h expected=%0h", 0, 1);
      summary();
      $finish;
    end
  end
endmodule